// File: doc/BRIEF.md
# Converter Strobe Sequencer for a Write-Then-Read Half-Flash ADC

This block sits between a simple request/response client and a parallel half-flash analog-to-digital converter run in its write-then-read mode. On a one-cycle start request it drives the converter's active-low chip-select, write and read strobes with widths and gaps counted in clock cycles. It then returns the 8-bit result and the over-range bit to the client with a one-cycle valid pulse. Every minimum time is a nanosecond parameter, rounded up to whole clock cycles.

The client picks one of three completion policies with each request. In the interrupt policy the block waits for the converter's end-of-conversion interrupt, which passes through a two-stage synchronizer, before it reads. If the interrupt does not arrive in time, the block reports a timeout. In the early policy the block ignores the interrupt and reads after a fixed delay, which ends the conversion early. In the pipelined policy write and read form one shared strobe. Each such strobe starts a new conversion and returns the result of the one before it. A pipelined result with no pipelined conversion before it is flagged as empty.

Top module: `adc_strobe_ctrl`

## Requirements
- R1: During and right after reset, chip-select, write and read are all high (inactive) and no response valid is given.
- R2: Every write low pulse lasts exactly ceil(WR_MIN_NS/CLK_NS) cycles (120 at the defaults), which is never more than WR_MAX_NS of clock time.
- R3: Chip-select is low in every cycle in which write or read is low, from at least one cycle before the first strobe falls until at least one cycle after the last strobe rises.
- R4: Interrupt policy (policy code 0, and also the unused code 3): read goes low only after the synchronized interrupt has been seen low. Data and over-range are captured after ceil(ACCESS_NS/CLK_NS) read cycles and returned as {rsp_ovf_o, rsp_data_o} with a one-cycle rsp_valid_o, with rsp_prior_o=0 and rsp_err_o=0.
- R5: Early policy (policy code 1): the interrupt is ignored, and read falls exactly ceil(RD_DELAY_NS/CLK_NS) cycles (120) after write rises. The value captured is the conversion just started.
- R6: At least ceil(RECOVER_NS/CLK_NS) cycles (100) separate the converter's interrupt going low from the next write falling edge.
- R7: Pipelined policy (policy code 2): write and read fall and rise in the same cycle. The response carries rsp_prior_o=1 and the result of the previous conversion.
- R8: A pipelined response has rsp_empty_o=1 when the request before it (or reset) was not a completed pipelined request. Otherwise rsp_empty_o=0.
- R9: In interrupt policy, if the synchronized interrupt stays high for INT_TIMEOUT_CYC cycles after write rises, read is never asserted. The block then gives one response with rsp_err_o=1 and zero data and over-range.
- R10: Start requests that arrive while a request is in progress are ignored. They change neither the policy in use nor the number of responses, which is exactly one per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start_i | input | 1 | One-cycle start request, accepted only when idle |
| req_policy_i | input | 2 | Completion policy: 0 interrupt, 1 early, 2 pipelined, 3 treated as 0 |
| adc_int_n_i | input | 1 | Converter end-of-conversion interrupt, active low, asynchronous |
| adc_data_i | input | 8 | Converter data bus |
| adc_ovf_i | input | 1 | Converter over-range output |
| adc_cs_n_o | output | 1 | Chip-select, active low |
| adc_wr_n_o | output | 1 | Write strobe, active low |
| adc_rd_n_o | output | 1 | Read strobe, active low |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_data_o | output | 8 | Captured conversion code |
| rsp_ovf_o | output | 1 | Captured over-range bit |
| rsp_prior_o | output | 1 | Response belongs to the previous conversion (pipelined) |
| rsp_empty_o | output | 1 | Pipelined response with no prior conversion; data meaningless |
| rsp_err_o | output | 1 | Interrupt timeout; data forced to zero |

## Verification
The bench runs all three policies against a bench-side converter model. The model latches a random sample on each write fall, finishes converting after a set delay and drives the interrupt. Running policies back to back separates "result of this conversion" from "result of the previous one" (R7) and exposes the empty flag after each policy change (R8). A directed early read against a slow conversion shows that read timing does not depend on the interrupt (R5). Runs with the interrupt suppressed and with extra start pulses during a request expose timeout handling and request filtering, which a plain interrupt run cannot.

// File: rtl/adc_strobe_pkg.sv
`timescale 1ns/1ps
package adc_strobe_pkg;

   typedef enum logic [1:0] {
      POL_INTR  = 2'd0,
      POL_EARLY = 2'd1,
      POL_PIPE  = 2'd2,
      POL_RSVD  = 2'd3
   } policy_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_WRITE,
      PH_DELAY,
      PH_WAIT,
      PH_READ,
      PH_HOLD,
      PH_RECOV
   } phase_e;

   // round a nanosecond figure up to whole clock cycles
   function automatic int ns_to_cycles(input int ns, input int period_ns);
      return (ns + period_ns - 1) / period_ns;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adc_strobe_sync.sv
`timescale 1ns/1ps
module adc_strobe_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("adc_strobe_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/adc_strobe_timer.sv
`timescale 1ns/1ps
module adc_strobe_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/adc_strobe_ctrl.sv
`timescale 1ns/1ps
module adc_strobe_ctrl
   import adc_strobe_pkg::*;
#(
   parameter int CLK_NS          = 5,
   parameter int DATA_W          = 8,
   parameter int WR_MIN_NS       = 600,
   parameter int WR_MAX_NS       = 50000,
   parameter int RD_DELAY_NS     = 600,
   parameter int ACCESS_NS       = 250,
   parameter int RECOVER_NS      = 500,
   parameter int INT_TIMEOUT_CYC = 400,
   parameter int SYNC_STAGES     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_start_i,
   input  logic [1:0]        req_policy_i,
   input  logic              adc_int_n_i,
   input  logic [DATA_W-1:0] adc_data_i,
   input  logic              adc_ovf_i,
   output logic              adc_cs_n_o,
   output logic              adc_wr_n_o,
   output logic              adc_rd_n_o,
   output logic              rsp_valid_o,
   output logic [DATA_W-1:0] rsp_data_o,
   output logic              rsp_ovf_o,
   output logic              rsp_prior_o,
   output logic              rsp_empty_o,
   output logic              rsp_err_o
);

   localparam int WR_CYC      = ns_to_cycles(WR_MIN_NS, CLK_NS);
   localparam int WR_MAX_CYC  = WR_MAX_NS / CLK_NS;
   localparam int DLY_CYC     = ns_to_cycles(RD_DELAY_NS, CLK_NS);
   localparam int ACC_CYC     = ns_to_cycles(ACCESS_NS, CLK_NS);
   localparam int REC_CYC     = ns_to_cycles(RECOVER_NS, CLK_NS);
   localparam int PIPE_REC    = DLY_CYC + REC_CYC;
   localparam int TMR_MAX     = max2(max2(WR_CYC, INT_TIMEOUT_CYC), max2(PIPE_REC, ACC_CYC));
   localparam int TW          = $clog2(TMR_MAX + 1);

   localparam logic [TW-1:0] LD_WR   = TW'(WR_CYC - 1);
   localparam logic [TW-1:0] LD_DLY  = TW'(DLY_CYC - 1);
   localparam logic [TW-1:0] LD_ACC  = TW'(ACC_CYC - 1);
   localparam logic [TW-1:0] LD_REC  = TW'(REC_CYC - 1);
   localparam logic [TW-1:0] LD_PREC = TW'(PIPE_REC - 1);
   localparam logic [TW-1:0] LD_TMO  = TW'(INT_TIMEOUT_CYC - 1);

   generate
      if (WR_CYC > WR_MAX_CYC) begin : g_bad_wr
         $error("adc_strobe_ctrl: minimum write width exceeds the maximum");
      end
      if (ACC_CYC > WR_CYC) begin : g_bad_acc
         $error("adc_strobe_ctrl: shared strobe shorter than data access time");
      end
      if (DLY_CYC < 1 || ACC_CYC < 1 || REC_CYC < 1 || INT_TIMEOUT_CYC < 1) begin : g_bad_min
         $error("adc_strobe_ctrl: every interval must be at least one cycle");
      end
   endgenerate

   phase_e          phase_q, phase_d;
   policy_e         pol_q;
   logic            tmr_load, tmr_zero;
   logic [TW-1:0]   tmr_val;
   logic            capture, timeout;
   logic            int_n_sync;
   logic            last_pipe_q;

   adc_strobe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_int_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (adc_int_n_i),
      .q     (int_n_sync)
   );

   adc_strobe_timer #(.W(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   always_comb begin
      phase_d  = phase_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      capture  = 1'b0;
      timeout  = 1'b0;
      unique case (phase_q)
         PH_IDLE:  if (req_start_i) phase_d = PH_SETUP;
         PH_SETUP: begin
            phase_d  = PH_WRITE;
            tmr_load = 1'b1;
            tmr_val  = LD_WR;
         end
         PH_WRITE: if (tmr_zero) begin
            if (pol_q == POL_PIPE) begin
               phase_d = PH_HOLD;
               capture = 1'b1;
            end else if (pol_q == POL_EARLY) begin
               phase_d  = PH_DELAY;
               tmr_load = 1'b1;
               tmr_val  = LD_DLY;
            end else begin
               phase_d  = PH_WAIT;
               tmr_load = 1'b1;
               tmr_val  = LD_TMO;
            end
         end
         PH_DELAY: if (tmr_zero) begin
            phase_d  = PH_READ;
            tmr_load = 1'b1;
            tmr_val  = LD_ACC;
         end
         PH_WAIT: begin
            if (!int_n_sync) begin
               phase_d  = PH_READ;
               tmr_load = 1'b1;
               tmr_val  = LD_ACC;
            end else if (tmr_zero) begin
               phase_d = PH_HOLD;
               timeout = 1'b1;
            end
         end
         PH_READ: if (tmr_zero) begin
            phase_d = PH_HOLD;
            capture = 1'b1;
         end
         PH_HOLD: begin
            phase_d  = PH_RECOV;
            tmr_load = 1'b1;
            tmr_val  = (pol_q == POL_PIPE) ? LD_PREC : LD_REC;
         end
         PH_RECOV: if (tmr_zero) phase_d = PH_IDLE;
         default:  phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         pol_q       <= POL_INTR;
         last_pipe_q <= 1'b0;
         rsp_valid_o <= 1'b0;
         rsp_data_o  <= '0;
         rsp_ovf_o   <= 1'b0;
         rsp_prior_o <= 1'b0;
         rsp_empty_o <= 1'b0;
         rsp_err_o   <= 1'b0;
      end else begin
         phase_q     <= phase_d;
         rsp_valid_o <= 1'b0;
         if (phase_q == PH_IDLE && req_start_i)
            pol_q <= (policy_e'(req_policy_i) == POL_RSVD) ? POL_INTR : policy_e'(req_policy_i);
         if (capture) begin
            rsp_valid_o <= 1'b1;
            rsp_data_o  <= adc_data_i;
            rsp_ovf_o   <= adc_ovf_i;
            rsp_err_o   <= 1'b0;
            rsp_prior_o <= (pol_q == POL_PIPE);
            rsp_empty_o <= (pol_q == POL_PIPE) && !last_pipe_q;
            last_pipe_q <= (pol_q == POL_PIPE);
         end else if (timeout) begin
            rsp_valid_o <= 1'b1;
            rsp_data_o  <= '0;
            rsp_ovf_o   <= 1'b0;
            rsp_err_o   <= 1'b1;
            rsp_prior_o <= 1'b0;
            rsp_empty_o <= 1'b0;
            last_pipe_q <= 1'b0;
         end
      end
   end

   assign adc_cs_n_o = (phase_q == PH_IDLE) || (phase_q == PH_RECOV);
   assign adc_wr_n_o = (phase_q != PH_WRITE);
   assign adc_rd_n_o = !((phase_q == PH_READ) ||
                         (phase_q == PH_WRITE && pol_q == POL_PIPE));

endmodule

// File: rtl/adc_strobe_ctrl_chk.sv
`timescale 1ns/1ps
module adc_strobe_ctrl_chk
   import adc_strobe_pkg::*;
#(
   parameter int CLK_NS    = 5,
   parameter int WR_MIN_NS = 600,
   parameter int WR_MAX_NS = 50000
) (
   input logic    clk,
   input logic    rst_n,
   input logic    cs_n,
   input logic    wr_n,
   input logic    rd_n,
   input logic    rsp_valid,
   input logic    int_seen_n,
   input policy_e pol
);

   localparam int WR_CYC     = ns_to_cycles(WR_MIN_NS, CLK_NS);
   localparam int WR_MAX_CYC = WR_MAX_NS / CLK_NS;

   int unsigned wr_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     wr_run <= 0;
      else if (!wr_n) wr_run <= wr_run + 1;
      else            wr_run <= 0;
   end

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |-> (cs_n && wr_n && rd_n && !rsp_valid));

   assert_wr_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_n) |-> (wr_run == WR_CYC));

   assert_wr_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_run <= WR_MAX_CYC);

   assert_cs_cover_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n || !rd_n) |-> !cs_n);

   assert_read_after_int_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rd_n) && pol == POL_INTR) |-> !$past(int_seen_n));

   assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_joint_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rd_n) && !wr_n) |-> $fell(wr_n));

   assert_overlap_pipe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n && !wr_n) |-> (pol == POL_PIPE));

endmodule

bind adc_strobe_ctrl adc_strobe_ctrl_chk #(
   .CLK_NS    (CLK_NS),
   .WR_MIN_NS (WR_MIN_NS),
   .WR_MAX_NS (WR_MAX_NS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_n       (adc_cs_n_o),
   .wr_n       (adc_wr_n_o),
   .rd_n       (adc_rd_n_o),
   .rsp_valid  (rsp_valid_o),
   .int_seen_n (int_n_sync),
   .pol        (pol_q)
);

// File: tb/adc_strobe_ctrl_bench.sv
`timescale 1ns/1ps
module adc_strobe_ctrl_bench;

   function automatic int cyc_of(input int ns);
      return (ns + 4) / 5;
   endfunction

   localparam int WR_CYC  = cyc_of(600);
   localparam int DLY_CYC = cyc_of(600);
   localparam int REC_CYC = cyc_of(500);
   localparam int FAST_CONV = 115;
   localparam int SLOW_CONV = 200;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_start = 1'b0;
   logic [1:0] req_policy = 2'd0;
   logic       adc_int_n = 1'b1;
   logic [7:0] adc_data = 8'd0;
   logic       adc_ovf = 1'b0;
   logic       adc_cs_n, adc_wr_n, adc_rd_n;
   logic       rsp_valid, rsp_ovf, rsp_prior, rsp_empty, rsp_err;
   logic [7:0] rsp_data;

   adc_strobe_ctrl u_adc_strobe_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_start_i  (req_start),
      .req_policy_i (req_policy),
      .adc_int_n_i  (adc_int_n),
      .adc_data_i   (adc_data),
      .adc_ovf_i    (adc_ovf),
      .adc_cs_n_o   (adc_cs_n),
      .adc_wr_n_o   (adc_wr_n),
      .adc_rd_n_o   (adc_rd_n),
      .rsp_valid_o  (rsp_valid),
      .rsp_data_o   (rsp_data),
      .rsp_ovf_o    (rsp_ovf),
      .rsp_prior_o  (rsp_prior),
      .rsp_empty_o  (rsp_empty),
      .rsp_err_o    (rsp_err)
   );

   always #2.5 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // converter model and port monitors
   bit       int_en = 1'b1;
   int       conv_len = FAST_CONV;
   int       cur_pol = 0;
   logic [8:0] vin_next = '0;
   logic [8:0] pend = '0;
   logic [8:0] outlatch = '0;
   bit       converting = 1'b0;
   int       conv_cnt = 0;
   int       cyc = 0;
   int       t_wr_rise = 0;
   int       t_int_fall = -100000;
   int       wr_low = 0;
   int       rd_falls = 0;
   int       valids = 0;
   logic     prev_wr = 1'b1, prev_rd = 1'b1;
   logic [8:0] got_val = '0;
   logic     got_prior = 1'b0, got_empty = 1'b0, got_err = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (converting) begin
            conv_cnt--;
            if (conv_cnt <= 0) begin
               converting = 1'b0;
               outlatch   = pend;
               if (int_en && adc_int_n) begin adc_int_n = 1'b0; t_int_fall = cyc; end
            end
         end
         if (prev_wr && !adc_wr_n) begin
            check(cyc - t_int_fall >= REC_CYC, "R6 recovery", cyc - t_int_fall, REC_CYC);
            check(!adc_cs_n, "R3 cs at write", adc_cs_n, 0);
            if (cur_pol == 2) check(!adc_rd_n, "R7 joint fall", adc_rd_n, 0);
            pend = vin_next;
            if (!adc_rd_n) {adc_ovf, adc_data} = outlatch;
            wr_low = 0;
         end
         if (!adc_wr_n) wr_low++;
         if (!prev_wr && adc_wr_n) begin
            check(wr_low == WR_CYC, "R2 write width", wr_low, WR_CYC);
            if (cur_pol == 2) check(adc_rd_n, "R7 joint rise", adc_rd_n, 1);
            t_wr_rise  = cyc;
            converting = 1'b1;
            conv_cnt   = conv_len;
         end
         if (prev_rd && !adc_rd_n && adc_wr_n) begin
            rd_falls++;
            if (cur_pol == 1)
               check(cyc - t_wr_rise == DLY_CYC, "R5 early delay", cyc - t_wr_rise, DLY_CYC);
            else
               check(!adc_int_n, "R4 read after interrupt", adc_int_n, 0);
            if (converting) begin
               converting = 1'b0;
               outlatch   = pend;
               if (int_en && adc_int_n) begin adc_int_n = 1'b0; t_int_fall = cyc; end
            end
            {adc_ovf, adc_data} = outlatch;
         end
         if (!prev_rd && adc_rd_n) adc_int_n = 1'b1;
         if ((!adc_wr_n || !adc_rd_n) && adc_cs_n) check(1'b0, "R3 strobe without cs", 1, 0);
         if (rsp_valid) begin
            valids++;
            got_val   = {rsp_ovf, rsp_data};
            got_prior = rsp_prior;
            got_empty = rsp_empty;
            got_err   = rsp_err;
         end
         prev_wr = adc_wr_n;
         prev_rd = adc_rd_n;
      end
   end

   function automatic bit exp_empty(input int pol, input bit prev_pipe);
      return (pol == 2) && !prev_pipe;
   endfunction

   function automatic logic [8:0] exp_value(input int pol, input logic [8:0] smp,
                                            input logic [8:0] prev_smp, input bit no_int);
      if (no_int)        return '0;
      else if (pol == 2) return prev_smp;
      else               return smp;
   endfunction

   logic [8:0] prev_smp = '0;
   bit         prev_pipe = 1'b0;

   task automatic run_req(input int pol, input bit extra_start, input bit no_int, input int clen);
      logic [8:0] smp;
      int rd_before;
      int wait_cyc;
      int eff_pol;
      bit ee;
      smp       = 9'($urandom);
      eff_pol   = (pol == 3) ? 0 : pol;
      vin_next  = smp;
      int_en    = !no_int;
      conv_len  = clen;
      cur_pol   = eff_pol;
      rd_before = rd_falls;
      valids    = 0;
      @(negedge clk);
      req_start  = 1'b1;
      req_policy = 2'(pol);
      @(negedge clk);
      req_start  = 1'b0;
      if (extra_start) begin
         repeat (30) @(negedge clk);
         req_start  = 1'b1;
         req_policy = 2'(eff_pol == 2 ? 1 : 2);
         @(negedge clk);
         req_start  = 1'b0;
      end
      wait_cyc = 0;
      while (valids == 0 && wait_cyc < 3000) begin
         @(negedge clk);
         wait_cyc++;
      end
      check(valids > 0, "R4 response arrives", valids, 1);
      repeat (DLY_CYC + REC_CYC + 8) @(negedge clk);
      check(valids == 1, "R10 one response per request", valids, 1);
      ee = exp_empty(eff_pol, prev_pipe);
      if (no_int) begin
         check(got_err == 1'b1, "R9 timeout error", got_err, 1);
         check(got_val == 9'd0, "R9 zero data", got_val, 0);
         check(rd_falls == rd_before, "R9 no read", rd_falls - rd_before, 0);
      end else if (eff_pol == 2) begin
         check(got_prior == 1'b1, "R7 prior tag", got_prior, 1);
         check(got_empty == ee, "R8 empty flag", got_empty, ee);
         if (!ee) check(got_val == exp_value(2, smp, prev_smp, 1'b0), "R7 previous data",
                        got_val, exp_value(2, smp, prev_smp, 1'b0));
      end else begin
         check(got_val == exp_value(eff_pol, smp, prev_smp, 1'b0),
               (eff_pol == 1) ? "R5 early data" : "R4 interrupt data",
               got_val, smp);
         check(got_prior == 1'b0 && got_err == 1'b0 && got_empty == 1'b0,
               "R4 flags clear", {got_prior, got_err, got_empty}, 0);
      end
      prev_smp  = smp;
      prev_pipe = (eff_pol == 2) && !no_int;
      int_en    = 1'b1;
      conv_len  = FAST_CONV;
   endtask

   initial begin
      int r;
      r = $urandom(1234);
      repeat (3) @(negedge clk);
      check(adc_cs_n && adc_wr_n && adc_rd_n && !rsp_valid, "R1 in reset",
            {adc_cs_n, adc_wr_n, adc_rd_n, rsp_valid}, 4'b1110);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(adc_cs_n && adc_wr_n && adc_rd_n && !rsp_valid, "R1 after reset",
            {adc_cs_n, adc_wr_n, adc_rd_n, rsp_valid}, 4'b1110);
      run_req(2, 1'b0, 1'b0, FAST_CONV);   // first pipelined: empty (R8)
      run_req(2, 1'b0, 1'b0, FAST_CONV);   // second: previous sample (R7)
      run_req(0, 1'b0, 1'b0, FAST_CONV);   // interrupt wait (R4)
      run_req(2, 1'b0, 1'b0, FAST_CONV);   // empty after non-pipelined (R8)
      run_req(1, 1'b0, 1'b0, SLOW_CONV);   // early read ends slow conversion (R5)
      run_req(0, 1'b0, 1'b1, FAST_CONV);   // timeout (R9)
      run_req(0, 1'b1, 1'b0, FAST_CONV);   // extra start ignored (R10)
      run_req(3, 1'b0, 1'b0, FAST_CONV);   // unused code acts as interrupt (R4)
      for (int i = 0; i < 30; i++) begin
         int p;
         p = int'($urandom_range(0, 3));
         run_req(p, ($urandom_range(0, 3) == 0), 1'b0,
                 (p == 1 && $urandom_range(0, 1) == 1) ? SLOW_CONV : FAST_CONV);
         repeat ($urandom_range(0, 6)) @(negedge clk);
      end
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule